// File: doc/BRIEF.md
# Hysteresis Vector-Selection Controller

This block is the decision stage of a direct torque controller for a three-phase induction motor. On each sample it compares signed fixed-point torque and flux references with their estimated values. A two-level comparator decides whether the stator flux magnitude must grow or shrink. A three-level comparator decides whether the torque must rise, fall or be held. A locator places the estimated stator flux vector in one of six 60-degree sectors, using its d and q components.

A selection table turns the flux decision, the torque decision and the sector into the three inverter leg states. It picks an active voltage vector when the torque must move. When the torque is held, it picks a zero vector, alternating between all-high and all-low with sector parity. The comparator states, the sector and the leg states are all registered on a one-cycle sample strobe and stay constant between strobes. Both hysteresis half-widths are run-time inputs.

The estimators upstream supply the references, the estimates and the flux components. The gate stage downstream takes the three leg states and applies dead time.

Top module: `dtc_vector_selector`

## Requirements
- R1: While `rst` is high and after its release, until the first strobe, the block shows `flux_up`=1, `torque_req`=0, `sector`=1 and `gate_abc`=3'b111.
- R2: Flux comparator. Let e = `flux_ref` − `flux_est`. On a strobe, `flux_up` becomes 1 if e > `flux_band` and becomes 0 if e < −`flux_band`. Otherwise it keeps its value, including when e equals ±`flux_band` and when the band is zero.
- R3: Torque comparator. Let e = `torque_ref` − `torque_est`, with b = `torque_band`. The output `torque_req` is encoded 2'b01 for +1, 2'b00 for 0 and 2'b11 for −1, and never takes the value 2'b10. On a strobe the output becomes +1 if e > b and −1 if e < −b. Otherwise, a +1 falls to 0 when e ≤ 0, a −1 rises to 0 when e ≥ 0, and every other case holds.
- R4: `sector` is a binary value from 1 to 6. The block sets |q|·2^16 against |d|·37837, that is tan 30° at 16 fractional bits. If |q|·2^16 is not greater, the sector is 1 when d ≥ 0 and 4 otherwise. If it is greater, the sector is 2 for q>0 and d>0, 3 for q>0 and d≤0, 6 for q<0 and d>0, and 5 for q<0 and d≤0.
- R5: `gate_abc` is {Sa,Sb,Sc}. The active vectors, in rotation order, are 100, 110, 010, 011, 001, 101. When the torque request is non-zero, the entries for sectors 1 to 6 are:
  - flux 1 and torque +1: 110, 010, 011, 001, 101, 100;
  - flux 1 and torque −1: 101, 100, 110, 010, 011, 001;
  - flux 0 and torque +1: 010, 011, 001, 101, 100, 110;
  - flux 0 and torque −1: 001, 101, 100, 110, 010, 011.
- R6: When the torque request is 0, `gate_abc` is 111 in odd sectors and 000 in even sectors, whatever the flux decision.
- R7: All outputs take their new values at the clock edge where `sample_stb` is high, so they are visible in the following cycle. With the strobe low, they do not change, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | One-cycle sample strobe |
| flux_ref | input | DW | Stator flux magnitude reference, signed |
| flux_est | input | DW | Estimated stator flux magnitude, signed |
| torque_ref | input | DW | Torque reference, signed |
| torque_est | input | DW | Estimated torque, signed |
| flux_d | input | DW | Estimated stator flux d component, signed |
| flux_q | input | DW | Estimated stator flux q component, signed |
| flux_band | input | DW-1 | Flux hysteresis half-width, unsigned |
| torque_band | input | DW-1 | Torque hysteresis half-width, unsigned |
| gate_abc | output | 3 | Registered leg states {Sa,Sb,Sc} |
| flux_up | output | 1 | Registered flux decision |
| torque_req | output | 2 | Registered torque decision (01 = +1, 00 = 0, 11 = −1) |
| sector | output | 3 | Registered flux sector, 1 to 6 |

## Verification
The sector locator is tried in three ways:
- A square grid of d/q points covers all quadrants and both axes.
- Pairs of points one LSB apart on each side of the 30° lines test the rounding of the tangent constant.
- Points with zero and full-scale negative components exercise the tie rules and the absolute-value edge.

The selection table is swept over every sector, flux decision and torque decision, using vectors at sector centres. This separates a wrong rotation offset from a wrong zero-vector parity. The two comparators receive error ramps that sit exactly on, just outside and inside their bands, and a zero band. These ramps distinguish the hold, the set and the return-to-zero paths. Input changes made with the strobe low show whether any register leaks an update.

// File: rtl/dtc_sel_pkg.sv
`timescale 1ns/1ps
package dtc_sel_pkg;

   // three-level torque decision, two's complement coding
   typedef enum logic [1:0] {
      TQ_ZERO = 2'b00,
      TQ_INC  = 2'b01,
      TQ_DEC  = 2'b11
   } torque_req_e;

   localparam int unsigned NUM_SECTORS = 6;

   // active voltage vectors in rotation order, {Sa,Sb,Sc}
   function automatic logic [2:0] active_vec(input logic [2:0] idx);
      logic [2:0] v;
      case (idx)
         3'd0:    v = 3'b100;
         3'd1:    v = 3'b110;
         3'd2:    v = 3'b010;
         3'd3:    v = 3'b011;
         3'd4:    v = 3'b001;
         default: v = 3'b101;
      endcase
      return v;
   endfunction

   // zero vector alternates with sector parity
   function automatic logic [2:0] zero_vec(input logic [2:0] sec);
      return sec[0] ? 3'b111 : 3'b000;
   endfunction

endpackage

// File: rtl/dtc_flux_hyst.sv
`timescale 1ns/1ps
module dtc_flux_hyst #(
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 stb,
   input  logic signed [DW-1:0] ref_i,
   input  logic signed [DW-1:0] est_i,
   input  logic        [DW-2:0] band_i,
   output logic                 state_nx,
   output logic                 state_q
);
   localparam int EW = DW + 1;

   logic signed [EW-1:0] err;
   logic signed [EW-1:0] band_s;
   logic                 above;
   logic                 below;

   assign err    = $signed({ref_i[DW-1], ref_i}) - $signed({est_i[DW-1], est_i});
   assign band_s = $signed({2'b00, band_i});
   assign above  = err > band_s;
   assign below  = err < -band_s;

   always_comb begin
      state_nx = state_q;
      if (above)      state_nx = 1'b1;
      else if (below) state_nx = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst)      state_q <= 1'b1;
      else if (stb) state_q <= state_nx;
   end

   // R2: inside the band the decision is held
   assert_flux_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (stb && !above && !below) |=> (state_q == $past(state_q)));
   // R2: outside the band the decision follows the sign of the error
   assert_flux_set_R2: assert property (@(posedge clk) disable iff (rst)
      (stb && above) |=> state_q);
   assert_flux_clear_R2: assert property (@(posedge clk) disable iff (rst)
      (stb && below) |=> !state_q);

endmodule

// File: rtl/dtc_torque_hyst.sv
`timescale 1ns/1ps
module dtc_torque_hyst
   import dtc_sel_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 stb,
   input  logic signed [DW-1:0] ref_i,
   input  logic signed [DW-1:0] est_i,
   input  logic        [DW-2:0] band_i,
   output torque_req_e          state_nx,
   output torque_req_e          state_q
);
   localparam int EW = DW + 1;

   logic signed [EW-1:0] err;
   logic signed [EW-1:0] band_s;
   logic                 above;
   logic                 below;
   logic                 err_nonpos;
   logic                 err_nonneg;

   assign err        = $signed({ref_i[DW-1], ref_i}) - $signed({est_i[DW-1], est_i});
   assign band_s     = $signed({2'b00, band_i});
   assign above      = err > band_s;
   assign below      = err < -band_s;
   assign err_nonpos = (err[EW-1] == 1'b1) || (err == '0);
   assign err_nonneg = (err[EW-1] == 1'b0);

   always_comb begin
      state_nx = state_q;
      if (above) begin
         state_nx = TQ_INC;
      end else if (below) begin
         state_nx = TQ_DEC;
      end else begin
         case (state_q)
            TQ_INC:  if (err_nonpos) state_nx = TQ_ZERO;
            TQ_DEC:  if (err_nonneg) state_nx = TQ_ZERO;
            default: state_nx = TQ_ZERO;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst)      state_q <= TQ_ZERO;
      else if (stb) state_q <= state_nx;
   end

   // R3: only the three legal codes appear
   assert_torque_code_R3: assert property (@(posedge clk) disable iff (rst)
      state_q != torque_req_e'(2'b10));
   // R3: a raise request cannot turn into a lower request without a large negative error
   assert_torque_no_jump_R3: assert property (@(posedge clk) disable iff (rst)
      (stb && state_q == TQ_INC && !below) |=> (state_q != TQ_DEC));
   // R3: held zero stays zero inside the band
   assert_torque_zero_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (stb && state_q == TQ_ZERO && !above && !below) |=> (state_q == TQ_ZERO));

endmodule

// File: rtl/dtc_sector_locate.sv
`timescale 1ns/1ps
module dtc_sector_locate #(
   parameter int DW            = 16,
   parameter int TAN_FRAC_BITS = 16
) (
   input  logic signed [DW-1:0] d_i,
   input  logic signed [DW-1:0] q_i,
   output logic        [2:0]    sector_o
);
   localparam int          PW        = DW + TAN_FRAC_BITS;
   localparam int unsigned TAN30_Q   = int'(0.5773502691896258 * real'(64'd1 << TAN_FRAC_BITS));
   localparam logic [TAN_FRAC_BITS-1:0] TAN_V = TAN_FRAC_BITS'(TAN30_Q);

   logic [DW-1:0] abs_d;
   logic [DW-1:0] abs_q;
   logic [PW-1:0] q_scaled;
   logic [PW-1:0] d_scaled;
   logic          near_d_axis;
   logic          d_nonneg;
   logic          d_pos;
   logic          q_pos;

   assign abs_d       = d_i[DW-1] ? (~d_i + 1'b1) : d_i;
   assign abs_q       = q_i[DW-1] ? (~q_i + 1'b1) : q_i;
   assign q_scaled    = {abs_q, {TAN_FRAC_BITS{1'b0}}};
   assign d_scaled    = PW'(abs_d) * PW'(TAN_V);
   assign near_d_axis = q_scaled <= d_scaled;
   assign d_nonneg    = !d_i[DW-1];
   assign d_pos       = d_nonneg && (d_i != '0);
   assign q_pos       = !q_i[DW-1];

   always_comb begin
      if (near_d_axis)  sector_o = d_nonneg ? 3'd1 : 3'd4;
      else if (q_pos)   sector_o = d_pos    ? 3'd2 : 3'd3;
      else              sector_o = d_pos    ? 3'd6 : 3'd5;
   end

endmodule

// File: rtl/dtc_vec_table.sv
`timescale 1ns/1ps
module dtc_vec_table
   import dtc_sel_pkg::*;
#(
   parameter int TABLE_STYLE = 0
) (
   input  logic        flux_up_i,
   input  torque_req_e torque_i,
   input  logic [2:0]  sector_i,
   output logic [2:0]  vec_o
);
   generate
      if (TABLE_STYLE == 0) begin : g_rotate
         // rotation offset from the sector's own vector
         logic [3:0] offset;
         logic [3:0] sum;
         logic [2:0] idx;

         always_comb begin
            if (flux_up_i) offset = (torque_i == TQ_INC) ? 4'd1 : 4'd5;
            else           offset = (torque_i == TQ_INC) ? 4'd2 : 4'd4;
            sum = {1'b0, sector_i} - 4'd1 + offset;
            idx = (sum >= 4'd6) ? 3'(sum - 4'd6) : sum[2:0];
         end

         assign vec_o = (torque_i == TQ_ZERO) ? zero_vec(sector_i) : active_vec(idx);
      end else begin : g_direct
         always_comb begin
            vec_o = zero_vec(sector_i);
            if (torque_i == TQ_INC && flux_up_i) begin
               case (sector_i)
                  3'd1: vec_o = 3'b110;  3'd2: vec_o = 3'b010;
                  3'd3: vec_o = 3'b011;  3'd4: vec_o = 3'b001;
                  3'd5: vec_o = 3'b101;  default: vec_o = 3'b100;
               endcase
            end else if (torque_i == TQ_DEC && flux_up_i) begin
               case (sector_i)
                  3'd1: vec_o = 3'b101;  3'd2: vec_o = 3'b100;
                  3'd3: vec_o = 3'b110;  3'd4: vec_o = 3'b010;
                  3'd5: vec_o = 3'b011;  default: vec_o = 3'b001;
               endcase
            end else if (torque_i == TQ_INC) begin
               case (sector_i)
                  3'd1: vec_o = 3'b010;  3'd2: vec_o = 3'b011;
                  3'd3: vec_o = 3'b001;  3'd4: vec_o = 3'b101;
                  3'd5: vec_o = 3'b100;  default: vec_o = 3'b110;
               endcase
            end else if (torque_i == TQ_DEC) begin
               case (sector_i)
                  3'd1: vec_o = 3'b001;  3'd2: vec_o = 3'b101;
                  3'd3: vec_o = 3'b100;  3'd4: vec_o = 3'b110;
                  3'd5: vec_o = 3'b010;  default: vec_o = 3'b011;
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dtc_vector_selector.sv
`timescale 1ns/1ps
module dtc_vector_selector
   import dtc_sel_pkg::*;
#(
   parameter int DW            = 16,
   parameter int TAN_FRAC_BITS = 16,
   parameter int TABLE_STYLE   = 0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sample_stb,
   input  logic signed [DW-1:0] flux_ref,
   input  logic signed [DW-1:0] flux_est,
   input  logic signed [DW-1:0] torque_ref,
   input  logic signed [DW-1:0] torque_est,
   input  logic signed [DW-1:0] flux_d,
   input  logic signed [DW-1:0] flux_q,
   input  logic        [DW-2:0] flux_band,
   input  logic        [DW-2:0] torque_band,
   output logic        [2:0]    gate_abc,
   output logic                 flux_up,
   output logic        [1:0]    torque_req,
   output logic        [2:0]    sector
);
   initial begin : elab_checks
      if (DW < 4 || DW > 32)
         $error("dtc_vector_selector: DW must lie in 4..32");
      if (TAN_FRAC_BITS < 8 || TAN_FRAC_BITS > 24)
         $error("dtc_vector_selector: TAN_FRAC_BITS must lie in 8..24");
      if (TABLE_STYLE != 0 && TABLE_STYLE != 1)
         $error("dtc_vector_selector: TABLE_STYLE must be 0 or 1");
   end

   logic        flux_nx;
   logic        flux_q_st;
   torque_req_e torque_nx;
   torque_req_e torque_q_st;
   logic [2:0]  sector_nx;
   logic [2:0]  vec_nx;
   logic [2:0]  sector_q;
   logic [2:0]  gate_q;

   dtc_flux_hyst #(.DW(DW)) u_flux (
      .clk     (clk),
      .rst     (rst),
      .stb     (sample_stb),
      .ref_i   (flux_ref),
      .est_i   (flux_est),
      .band_i  (flux_band),
      .state_nx(flux_nx),
      .state_q (flux_q_st)
   );

   dtc_torque_hyst #(.DW(DW)) u_torque (
      .clk     (clk),
      .rst     (rst),
      .stb     (sample_stb),
      .ref_i   (torque_ref),
      .est_i   (torque_est),
      .band_i  (torque_band),
      .state_nx(torque_nx),
      .state_q (torque_q_st)
   );

   dtc_sector_locate #(.DW(DW), .TAN_FRAC_BITS(TAN_FRAC_BITS)) u_sector (
      .d_i     (flux_d),
      .q_i     (flux_q),
      .sector_o(sector_nx)
   );

   dtc_vec_table #(.TABLE_STYLE(TABLE_STYLE)) u_table (
      .flux_up_i(flux_nx),
      .torque_i (torque_nx),
      .sector_i (sector_nx),
      .vec_o    (vec_nx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sector_q <= 3'd1;
         gate_q   <= 3'b111;
      end else if (sample_stb) begin
         sector_q <= sector_nx;
         gate_q   <= vec_nx;
      end
   end

   assign gate_abc   = gate_q;
   assign flux_up    = flux_q_st;
   assign torque_req = torque_q_st;
   assign sector     = sector_q;

   // R7: nothing moves without a strobe
   assert_hold_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
      (!$past(sample_stb) && !$past(rst)) |->
         ($stable(gate_abc) && $stable(sector) && $stable(flux_up) && $stable(torque_req)));
   // R4: sector stays in its legal range
   assert_sector_range_R4: assert property (@(posedge clk) disable iff (rst)
      (sector >= 3'd1) && (sector <= 3'd6));
   // R6: held torque pairs with the parity zero vector
   assert_zero_parity_R6: assert property (@(posedge clk) disable iff (rst)
      (torque_req == TQ_ZERO) |-> (gate_abc == (sector[0] ? 3'b111 : 3'b000)));
   // R5: torque change always pairs with an active vector
   assert_active_vec_R5: assert property (@(posedge clk) disable iff (rst)
      (torque_req != TQ_ZERO) |-> (gate_abc != 3'b000 && gate_abc != 3'b111));

endmodule

// File: tb/dtc_vector_selector_tb_top.sv
`timescale 1ns/1ps
module dtc_vector_selector_tb_top;
   localparam int  DW   = 16;
   localparam longint TANQ = longint'(0.5773502691896258 * 65536.0);

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 sample_stb = 1'b0;
   logic signed [DW-1:0] flux_ref = '0, flux_est = '0;
   logic signed [DW-1:0] torque_ref = '0, torque_est = '0;
   logic signed [DW-1:0] flux_d = '0, flux_q = '0;
   logic        [DW-2:0] flux_band = '0, torque_band = '0;
   logic [2:0] gate_abc;
   logic       flux_up;
   logic [1:0] torque_req;
   logic [2:0] sector;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int m_flux = 1;
   int m_tq = 0;
   int m_sec = 1;

   always #4 clk = ~clk;

   dtc_vector_selector dut_i (
      .clk(clk), .rst(rst), .sample_stb(sample_stb),
      .flux_ref(flux_ref), .flux_est(flux_est),
      .torque_ref(torque_ref), .torque_est(torque_est),
      .flux_d(flux_d), .flux_q(flux_q),
      .flux_band(flux_band), .torque_band(torque_band),
      .gate_abc(gate_abc), .flux_up(flux_up),
      .torque_req(torque_req), .sector(sector)
   );

   function automatic int tq_int(input logic [1:0] c);
      case (c)
         2'b01:   return 1;
         2'b00:   return 0;
         2'b11:   return -1;
         default: return 99;
      endcase
   endfunction

   function automatic int exp_sector(input int d, input int q);
      longint ad = (d < 0) ? -d : d;
      longint aq = (q < 0) ? -q : q;
      if (aq * 65536 <= ad * TANQ) return (d >= 0) ? 1 : 4;
      if (q > 0) return (d > 0) ? 2 : 3;
      return (d > 0) ? 6 : 5;
   endfunction

   // selection table written out from the requirements
   function automatic int exp_gate(input int fl, input int tq, input int n);
      int t [4][6] = '{
         '{6, 2, 3, 1, 5, 4},   // flux 1, torque +1
         '{5, 4, 6, 2, 3, 1},   // flux 1, torque -1
         '{2, 3, 1, 5, 4, 6},   // flux 0, torque +1
         '{1, 5, 4, 6, 2, 3}};  // flux 0, torque -1
      if (tq == 0) return (n % 2 == 1) ? 7 : 0;
      return t[(fl ? 0 : 2) + (tq > 0 ? 0 : 1)][n-1];
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check({req, " gate"},   int'(gate_abc), exp_gate(m_flux, m_tq, m_sec));
      check({req, " flux"},   int'(flux_up),  m_flux);
      check({req, " torque"}, tq_int(torque_req), m_tq);
      check({req, " sector"}, int'(sector),   m_sec);
   endtask

   task automatic drive(input int fe, input int te, input int d, input int q,
                        input int fb, input int tb);
      flux_ref    = DW'(fe);
      flux_est    = '0;
      torque_ref  = DW'(te);
      torque_est  = '0;
      flux_d      = DW'(d);
      flux_q      = DW'(q);
      flux_band   = (DW-1)'(fb);
      torque_band = (DW-1)'(tb);
   endtask

   // one strobed sample, model update, check one cycle later
   task automatic sample(input int fe, input int te, input int d, input int q,
                         input int fb, input int tb, input string req);
      @(negedge clk);
      drive(fe, te, d, q, fb, tb);
      sample_stb = 1'b1;
      @(negedge clk);
      sample_stb = 1'b0;
      if (fe > fb) m_flux = 1;
      else if (fe < -fb) m_flux = 0;
      if (te > tb) m_tq = 1;
      else if (te < -tb) m_tq = -1;
      else if (m_tq == 1 && te <= 0) m_tq = 0;
      else if (m_tq == -1 && te >= 0) m_tq = 0;
      m_sec = exp_sector(d, q);
      check_all(req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog R7 act=hung exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int cd [6] = '{8000, 4000, -4000, -8000, -4000, 4000};
      int cq [6] = '{0, 6928, 6928, 0, -6928, -6928};
      int qb;

      repeat (4) @(negedge clk);
      // R1 reset state, during and after reset
      check_all("R1 in reset");
      rst = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_all("R1 after release");

      // R7: inputs change with strobe low, outputs stay put
      drive(5000, -5000, -8000, 100, 10, 10);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check_all("R7 no strobe");
      end
      sample(5000, -5000, -8000, 100, 10, 10, "R7 strobed update");
      drive(-5000, 5000, 100, 8000, 10, 10);
      repeat (3) @(negedge clk);
      check_all("R7 hold after strobe");

      // R4 and R6: sector grid with torque error zero (torque goes to 0)
      for (int d = -8000; d <= 8000; d += 2000)
         for (int q = -8000; q <= 8000; q += 2000)
            sample(0, 0, d, q, 100, 100, "R4 grid");

      // R4 boundary points around the 30 degree lines
      qb = int'((64'sd10000 * TANQ) >>> 16);
      sample(0, 0, 10000, qb, 100, 100, "R4 edge s1");
      sample(0, 0, 10000, qb + 1, 100, 100, "R4 edge s2");
      sample(0, 0, 10000, -qb - 1, 100, 100, "R4 edge s6");
      sample(0, 0, -10000, qb, 100, 100, "R4 edge s4");
      sample(0, 0, -10000, qb + 1, 100, 100, "R4 edge s3");
      sample(0, 0, -10000, -qb - 1, 100, 100, "R4 edge s5");
      sample(0, 0, 0, 100, 100, 100, "R4 d zero q pos");
      sample(0, 0, 0, -100, 100, 100, "R4 d zero q neg");
      sample(0, 0, 0, 0, 100, 100, "R4 origin");
      sample(0, 0, -32768, 0, 100, 100, "R4 d fullscale neg");
      sample(0, 0, 0, -32768, 100, 100, "R4 q fullscale neg");

      // R5 and R6: full table sweep at sector centres
      for (int n = 0; n < 6; n++)
         for (int fl = 0; fl < 2; fl++)
            for (int tq = -1; tq <= 1; tq++)
               sample(fl ? 500 : -500, tq * 500, cd[n], cq[n], 100, 100, "R5 R6 table");

      // R2 flux hysteresis, band 200
      sample(300, 0, 8000, 0, 200, 100, "R2 set");
      sample(-200, 0, 8000, 0, 200, 100, "R2 on lower edge");
      sample(-150, 0, 8000, 0, 200, 100, "R2 inside");
      sample(-201, 0, 8000, 0, 200, 100, "R2 clear");
      sample(200, 0, 8000, 0, 200, 100, "R2 on upper edge");
      sample(50, 0, 8000, 0, 200, 100, "R2 inside low");
      sample(201, 0, 8000, 0, 200, 100, "R2 set again");
      sample(0, 0, 8000, 0, 0, 100, "R2 zero band hold");
      sample(-1, 0, 8000, 0, 0, 100, "R2 zero band clear");
      sample(0, 0, 8000, 0, 0, 100, "R2 zero band hold low");
      sample(1, 0, 8000, 0, 0, 100, "R2 zero band set");

      // R3 torque three-level hysteresis, band 200
      sample(0, 201, 4000, 6928, 100, 200, "R3 raise");
      sample(0, 200, 4000, 6928, 100, 200, "R3 hold raise edge");
      sample(0, 1, 4000, 6928, 100, 200, "R3 hold raise");
      sample(0, 0, 4000, 6928, 100, 200, "R3 raise to zero");
      sample(0, -200, 4000, 6928, 100, 200, "R3 zero on edge");
      sample(0, -201, 4000, 6928, 100, 200, "R3 lower");
      sample(0, -1, 4000, 6928, 100, 200, "R3 hold lower");
      sample(0, 0, 4000, 6928, 100, 200, "R3 lower to zero");
      sample(0, 150, 4000, 6928, 100, 200, "R3 zero inside");
      sample(0, 201, 4000, 6928, 100, 200, "R3 raise again");
      sample(0, -201, 4000, 6928, 100, 200, "R3 direct reversal");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule